// File: doc/BRIEF.md
# Wake Pin Event Detector

This block watches a small group of external wake pins (up to eight) and turns a chosen condition on each pin into a sticky status bit. Every pin has its own configuration word. That word selects one of six behaviours: detection off, level low, level high, falling edge, rising edge, or any edge. The same word also returns the pin's synchronized level when read, and it carries a write-only bit that restarts the pin.

Software programs the modes and an enable mask through a plain 32-bit register port. A single interrupt line rises whenever an enabled status bit is set. Software acknowledges events by writing ones to a clear register.

Each pin is first passed through a two-flop synchronizer. Edges are found by comparing the synchronized sample with the sample taken one clock earlier. Status bits collect events whether or not they are enabled, so a poll of the status register sees every detected event.

Top module: `wake_detect_top`

## Requirements
- R1: After reset, every configuration word holds mode code 4 (no detection), the status register (0x310) and the enable register (0x314) read zero, and the interrupt output is low.
- R2: The configuration word of pin n is at byte address 0x330 + 8*n. On a read, bits [3:1] return the mode code last written and bit 0 returns the synchronized pin level. Bit 4 and all higher bits read 0.
- R3: Mode 0 (level low) and mode 1 (level high) set the pin's status bit (bit n of 0x310) on every clock while the pin is at the chosen level. Once the pin leaves that level, a cleared bit stays clear.
- R4: Mode 2 sets status only on a falling edge and mode 3 only on a rising edge. An edge in the other direction leaves the status bit unchanged.
- R5: Mode 6 sets status on both rising and falling edges.
- R6: Mode codes 4, 5 and 7 never set the status bit, whatever the pin does.
- R7: Status bits record events regardless of the enable register. The interrupt output is high exactly when some bit is set in both status and enable (0x314, bit n for pin n).
- R8: Writing the clear register (0x318) clears each status bit whose data bit is 1. A data bit of 0 leaves that status bit as it was.
- R9: In a level mode, a status bit cleared while its level condition still holds reads 0 in the cycle after the clear write and is set again one clock later.
- R10: Writing 1 to bit 4 of a configuration word clears that pin's status bit and drops any edge seen in that cycle. The mode in the same write still takes effect.
- R11: A pin change is seen in status on the third rising clock edge after it reaches the input: two synchronizer stages, then the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NPINS | Asynchronous wake pins |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Shared interrupt: OR of status AND enable |

## Verification
Each mode code is tried with a rising pin and with a falling pin, so that an edge mode is separated from its opposite direction and from the any-edge code. A level mode is distinguished from an edge mode by a level held across a clear. The reserved codes and the off code see the same toggles and must stay silent. The exact read timing after a pin change checks the synchronizer depth. A clear while a level persists shows the one-cycle dip. Clear writes that mix zeros and ones, and enable patterns that do and do not overlap the set status, separate the acknowledge path from the interrupt gating.

// File: rtl/wakedet_pkg.sv
package wakedet_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h310;
    localparam logic [ADDR_W-1:0] OFS_ENABLE = 12'h314;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 12'h318;
    localparam logic [ADDR_W-1:0] OFS_PINCFG = 12'h330;
    localparam int               PIN_STRIDE_LG = 3;   // 8-byte stride per pin
    localparam int               CFG_RST_BIT   = 4;

    typedef enum logic [2:0] {
        MD_LOW  = 3'd0,
        MD_HIGH = 3'd1,
        MD_FALL = 3'd2,
        MD_RISE = 3'd3,
        MD_OFF  = 3'd4,
        MD_RSV5 = 3'd5,
        MD_ANY  = 3'd6,
        MD_RSV7 = 3'd7
    } wmode_e;

    // Level-type and edge-type hits are kept apart: a clear overrides a
    // level hit for one cycle but never swallows an edge.
    typedef struct packed {
        logic lvl;
        logic edg;
    } hit_t;

    typedef struct packed {
        logic stat_sel;
        logic en_sel;
        logic clr_sel;
    } regsel_t;

    function automatic hit_t classify(wmode_e m, logic cur, logic prv);
        hit_t h;
        h = '0;
        case (m)
            MD_LOW:  h.lvl = ~cur;
            MD_HIGH: h.lvl = cur;
            MD_FALL: h.edg = prv & ~cur;
            MD_RISE: h.edg = ~prv & cur;
            MD_ANY:  h.edg = prv ^ cur;
            default: h = '0;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/wakedet_sync.sv
module wakedet_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-2:0], d};
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/wakedet_decode.sv
module wakedet_decode
    import wakedet_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output regsel_t           sel,
    output logic [NPINS-1:0]  cfg_sel
);
    localparam int IW = ADDR_W - PIN_STRIDE_LG;

    logic [ADDR_W-1:0] off;
    logic [IW-1:0]     idx;
    logic              in_rng;

    always_comb begin
        sel.stat_sel = (addr == OFS_STATUS);
        sel.en_sel   = (addr == OFS_ENABLE);
        sel.clr_sel  = (addr == OFS_CLEAR);

        off    = addr - OFS_PINCFG;
        idx    = off[ADDR_W-1:PIN_STRIDE_LG];
        in_rng = (addr >= OFS_PINCFG) && (off[PIN_STRIDE_LG-1:0] == '0)
                 && (idx < IW'(NPINS));
        for (int i = 0; i < NPINS; i++) begin
            cfg_sel[i] = in_rng && (idx == IW'(i));
        end
    end
endmodule

// File: rtl/wakedet_chan.sv
module wakedet_chan
    import wakedet_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   pin_raw,
    input  logic   cfg_we,
    input  logic [2:0] cfg_mode,
    input  logic   cfg_rst,
    input  logic   clr,
    output logic   stat,
    output logic   level,
    output wmode_e mode,
    output logic   edge_hit
);
    logic   cur;
    logic   prv_q;
    logic   stat_q;
    wmode_e mode_q;
    hit_t   h;

    wakedet_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_raw),
        .q   (cur)
    );

    always_comb h = classify(mode_q, cur, prv_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prv_q  <= 1'b0;
            mode_q <= MD_OFF;
            stat_q <= 1'b0;
        end else begin
            prv_q <= cur;
            if (cfg_we) mode_q <= wmode_e'(cfg_mode);
            if (cfg_we && cfg_rst) stat_q <= 1'b0;
            else stat_q <= h.edg | ((stat_q | h.lvl) & ~clr);
        end
    end

    assign stat     = stat_q;
    assign level    = cur;
    assign mode     = mode_q;
    assign edge_hit = h.edg;
endmodule

// File: rtl/wake_detect_top.sv
module wake_detect_top
    import wakedet_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPINS-1:0]  pin_i,
    input  logic              bus_wr,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o
);
    regsel_t              sel;
    logic [NPINS-1:0]     cfg_sel;
    logic [NPINS-1:0]     stat_v;
    logic [NPINS-1:0]     lvl_v;
    logic [NPINS-1:0]     edge_hit;
    logic [NPINS-1:0][2:0] mode_v;
    logic [NPINS-1:0]     en_q;

    wakedet_decode #(.NPINS(NPINS)) u_dec (
        .addr    (bus_addr),
        .sel     (sel),
        .cfg_sel (cfg_sel)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        wmode_e m;
        wakedet_chan #(.SYNC_STAGES(SYNC_STAGES)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .pin_raw  (pin_i[g]),
            .cfg_we   (bus_wr && cfg_sel[g]),
            .cfg_mode (bus_wdata[3:1]),
            .cfg_rst  (bus_wdata[CFG_RST_BIT]),
            .clr      (bus_wr && sel.clr_sel && bus_wdata[g]),
            .stat     (stat_v[g]),
            .level    (lvl_v[g]),
            .mode     (m),
            .edge_hit (edge_hit[g])
        );
        assign mode_v[g] = m;
    end

    always_ff @(posedge clk) begin
        if (rst)                      en_q <= '0;
        else if (bus_wr && sel.en_sel) en_q <= bus_wdata[NPINS-1:0];
    end

    always_comb begin
        bus_rdata = '0;
        if (sel.stat_sel) bus_rdata[NPINS-1:0] = stat_v;
        if (sel.en_sel)   bus_rdata[NPINS-1:0] = en_q;
        for (int i = 0; i < NPINS; i++) begin
            if (cfg_sel[i]) bus_rdata[3:0] = {mode_v[i], lvl_v[i]};
        end
    end

    assign irq_o = |(stat_v & en_q);
endmodule

// File: rtl/wakedet_chk.sv
module wakedet_chk
    import wakedet_pkg::*;
#(
    parameter int NPINS = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_wr,
    input logic [11:0]          bus_addr,
    input logic [31:0]          bus_wdata,
    input logic [NPINS-1:0]     status,
    input logic [NPINS-1:0]     enable,
    input logic [NPINS-1:0]     edge_hit,
    input logic [3*NPINS-1:0]   mode_flat,
    input logic                 irq
);
    logic [NPINS-1:0] quiet;
    logic [NPINS-1:0] clr_req;
    logic [NPINS-1:0] rst_req;

    for (genvar g = 0; g < NPINS; g++) begin : g_m
        logic [2:0] m;
        assign m = mode_flat[3*g +: 3];
        assign quiet[g] = (m == 3'd4) || (m == 3'd5) || (m == 3'd7);
        assign rst_req[g] = bus_wr && bus_wdata[CFG_RST_BIT]
                            && (bus_addr == OFS_PINCFG + 12'(8*g));
        assign clr_req[g] = bus_wr && (bus_addr == OFS_CLEAR) && bus_wdata[g];
    end

    // R1: state leaving reset is clean
    p_reset_clean_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (status == '0 && enable == '0 && !irq));

    // R6: a quiet mode never raises a status bit
    p_quiet_mode_r6: assert property (@(posedge clk) disable iff (rst)
        (status & ~$past(status) & $past(quiet)) == '0);

    // R8: a requested clear takes effect unless an edge arrives with it
    p_clear_takes_r8: assert property (@(posedge clk) disable iff (rst)
        (clr_req != '0) |=> ((status & $past(clr_req) & ~$past(edge_hit)) == '0));

    // R8: status bits only fall through a clear or a pin restart
    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(status) & ~status & ~$past(clr_req | rst_req)) == '0);

    // R7: the interrupt needs some enable bit
    p_irq_gated_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (enable != '0));
endmodule

bind wake_detect_top wakedet_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .status    (stat_v),
    .enable    (en_q),
    .edge_hit  (edge_hit),
    .mode_flat (mode_v),
    .irq       (irq_o)
);

// File: tb/sim_wake_detect_top.sv
`timescale 1ns/100ps
module sim_wake_detect_top;
    localparam int NP = 8;
    localparam logic [11:0] A_STAT = 12'h310;
    localparam logic [11:0] A_EN   = 12'h314;
    localparam logic [11:0] A_CLR  = 12'h318;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [NP-1:0] pin_i = '0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    always #2.5 clk = ~clk;

    wake_detect_top #(.NPINS(NP)) u0 (
        .clk (clk), .rst (rst), .pin_i (pin_i),
        .bus_wr (bus_wr), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata), .irq_o (irq_o)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] mask;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    function automatic logic [11:0] cfg(int n);
        return 12'h330 + 12'(8*n);
    endfunction

    // monitor: compares in the same cycle, well before the next rising edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] got;
                it = q.pop_front();
                got = it.is_irq ? {31'd0, irq_o} : (bus_rdata & it.mask);
                n_chk++;
                if (got !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: got 0x%08h expected 0x%08h", it.tag, got, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] m,
                      input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_addr = a;
        #1;
        it.is_irq = 1'b0; it.mask = m; it.exp = e; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic irq_is(input logic e, input string tag);
        item_t it;
        @(negedge clk);
        #1;
        it.is_irq = 1'b1; it.mask = 32'h1; it.exp = {31'd0, e}; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic pin(input int i, input logic v);
        @(negedge clk);
        pin_i[i] = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd(A_STAT, 32'hFFFF_FFFF, 32'h0, "R1 status");
        rd(A_EN,   32'hFFFF_FFFF, 32'h0, "R1 enable");
        rd(cfg(0), 32'hFFFF_FFFF, 32'h8, "R1 cfg0");
        rd(cfg(7), 32'hFFFF_FFFF, 32'h8, "R1 cfg7");
        irq_is(1'b0, "R1 irq");

        // R2 readback, R10 reset bit reads 0
        pin(3, 1'b1); idle(3);
        rd(cfg(3), 32'hFFFF_FFFF, 32'h9, "R2 level readback");
        wr(cfg(3), 32'h1E);
        rd(cfg(3), 32'hFFFF_FFFF, 32'hF, "R2 R10 mode7 readback");

        // R6 quiet codes
        wr(cfg(4), 32'h0A);
        wr(cfg(5), 32'h08);
        pin(3, 1'b0); pin(4, 1'b1); pin(5, 1'b1); idle(4);
        pin(3, 1'b1); pin(4, 1'b0); pin(5, 1'b0); idle(4);
        rd(A_STAT, 32'h38, 32'h0, "R6 codes 4 5 7 silent");

        // R11 latency and R4 rising only
        wr(cfg(0), 32'h06);
        pin(0, 1'b1);
        rd(A_STAT, 32'h01, 32'h0, "R11 not after edge 1");
        rd(A_STAT, 32'h01, 32'h0, "R11 not after edge 2");
        rd(A_STAT, 32'h01, 32'h1, "R11 set after edge 3");
        wr(A_CLR, 32'h01);
        pin(0, 1'b0); idle(4);
        rd(A_STAT, 32'h01, 32'h0, "R4 rise mode ignores fall");

        // R4 falling only
        wr(cfg(1), 32'h04);
        pin(1, 1'b1); idle(4);
        rd(A_STAT, 32'h02, 32'h0, "R4 fall mode ignores rise");
        pin(1, 1'b0); idle(4);
        rd(A_STAT, 32'h02, 32'h2, "R4 fall mode sets");

        // R8 clear semantics
        wr(A_CLR, 32'h00);
        rd(A_STAT, 32'h02, 32'h2, "R8 zero write keeps bit");
        wr(A_CLR, 32'hFD);
        rd(A_STAT, 32'h02, 32'h2, "R8 other ones keep bit");
        wr(A_CLR, 32'h02);
        rd(A_STAT, 32'h02, 32'h0, "R8 one clears bit");

        // R5 any edge
        wr(cfg(2), 32'h0C);
        pin(2, 1'b1); idle(4);
        rd(A_STAT, 32'h04, 32'h4, "R5 rise sets");
        wr(A_CLR, 32'h04);
        rd(A_STAT, 32'h04, 32'h0, "R5 cleared");
        pin(2, 1'b0); idle(4);
        rd(A_STAT, 32'h04, 32'h4, "R5 fall sets");
        wr(A_CLR, 32'h04);

        // R3 level modes
        wr(cfg(6), 32'h02);
        idle(3);
        rd(A_STAT, 32'h40, 32'h0, "R3 high mode with low pin");
        pin(6, 1'b1); idle(4);
        rd(A_STAT, 32'h40, 32'h40, "R3 high mode sets");
        wr(cfg(7), 32'h00);
        idle(2);
        rd(A_STAT, 32'h80, 32'h80, "R3 low mode sets");

        // R9 re-set after clear while level holds
        wr(A_CLR, 32'h80);
        rd(A_STAT, 32'h80, 32'h0, "R9 dip after clear");
        rd(A_STAT, 32'h80, 32'h80, "R9 set again");
        pin(7, 1'b1); idle(4);
        wr(A_CLR, 32'h80); idle(2);
        rd(A_STAT, 32'h80, 32'h0, "R3 stays clear off level");

        // R7 gating
        rd(A_STAT, 32'hFF, 32'h40, "R7 status without enable");
        irq_is(1'b0, "R7 irq low when disabled");
        wr(A_EN, 32'h41);
        irq_is(1'b1, "R7 irq high on overlap");
        rd(A_EN, 32'hFFFF_FFFF, 32'h41, "R7 enable readback");
        wr(A_EN, 32'h01);
        irq_is(1'b0, "R7 irq low no overlap");

        // R10 pin restart
        pin(2, 1'b1); idle(4);
        rd(A_STAT, 32'h04, 32'h4, "R10 setup");
        wr(cfg(2), 32'h1C);
        rd(A_STAT, 32'h04, 32'h0, "R10 status cleared");
        rd(cfg(2), 32'hFFFF_FFFF, 32'hD, "R10 mode kept");
        pin(2, 1'b0); idle(4);
        rd(A_STAT, 32'h04, 32'h4, "R10 detection resumes");

        idle(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule